// File: doc/BRIEF.md
# SDRAM read burst output sequencer

This block models the read side of a synchronous DRAM as seen from the device. Each rising clock edge samples one decoded command. That command is either a READ, carrying a bank, a starting column and an auto-precharge flag, or no command at all. After a READ, the block walks the column sequence of the burst and fetches each word from a behavioural open-row model, one row per bank. The words pass through a latency pipeline and are driven onto a tri-state data bus. A separate enable output shows when the bus is driven.

Burst length and CAS latency come from static configuration inputs. A newer READ that arrives during a burst cuts that burst short. It only redirects the column generator, so the words already in the latency pipeline still leave in order, and the bus stays busy without a gap. If the auto-precharge flag was set for a fixed-length burst that runs to its end, a one-cycle per-bank precharge-done pulse is raised.

Top module: `sdram_rd_seq`

## Requirements
- R1: With `cfg_cas_lat` = 2 or 3, the first word of a READ sampled at clock edge n is driven during the cycle that follows edge n+CL-1, so it is valid at edge n+CL.
- R2: `cfg_burst` selects the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The words of a burst follow one another on consecutive cycles with no idle cycle.
- R3: A fixed-length burst counts its columns upward, one per word. The count wraps inside the aligned block of burst-length columns that holds the starting column.
- R4: A full-page burst advances one column per cycle. After the last column (2^COL_W-1) it wraps to column 0. It ends only when a new READ arrives.
- R5: A READ sampled during an active burst truncates it. The first word of the new burst is driven in the cycle right after the last word the old burst issued before that edge.
- R6: A READ sampled exactly burst-length cycles after the previous READ gives back-to-back data with no idle cycle.
- R7: When no burst word is due, `dq_oe` is 0 and `dq` is released to high impedance. This is also the state after reset, where `pre_done` is all zero as well.
- R8: When `cmd_ap` is 1 with a fixed-length READ that completes, `pre_done` pulses for exactly one cycle. The pulse is one-hot on bit `cmd_ba` and appears in the cycle after the last word is driven.
- R9: No `pre_done` pulse appears for a burst whose `cmd_ap` was 0, for a fixed-length burst truncated before its last word, or for a full-page burst.
- R10: The word stored at bank b and column c is the low DATA_W bits of (91*b + 29*c + 167).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 2 | CAS latency, 2 or 3 |
| cfg_burst | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| cmd_read | input | 1 | READ command strobe, sampled at the rising edge |
| cmd_ba | input | BA_W | Bank of the READ |
| cmd_col | input | COL_W | Starting column of the READ |
| cmd_ap | input | 1 | Auto-precharge request sampled with the READ |
| dq | inout | DATA_W | Tri-state read data bus |
| dq_oe | output | 1 | High while a burst word is driven on `dq` |
| pre_done | output | BANKS | One-cycle per-bank precharge-done pulse |

## Verification
The bench builds the block with DATA_W=8, BANKS=4 and COL_W=5, which gives 32-column pages. With that page size, a full-page burst started near the top of the page wraps past column 31 within a few cycles, and it can run through the page more than once within a short run. Both CAS latencies are exercised with every fixed burst length. The bench also covers unaligned starting columns, spacings that give both truncation and exact back-to-back READs, and auto precharge on completed, truncated and full-page bursts.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

    // burst length codes on cfg_burst
    localparam logic [2:0] BURST_PAGE = 3'd7;

    // contents of the behavioural open row: a fixed function of bank and column
    function automatic logic [31:0] row_word(input logic [31:0] bank, input logic [31:0] col);
        return bank * 32'd91 + col * 32'd29 + 32'd167;
    endfunction

endpackage

// File: rtl/sdram_col_gen.sv
module sdram_col_gen #(
    parameter int COL_W = 9,
    parameter int BA_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_read,
    input  logic [BA_W-1:0]  cmd_ba,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_ap,
    input  logic [2:0]       cfg_burst,
    output logic             issue_v,
    output logic [BA_W-1:0]  issue_ba,
    output logic [COL_W-1:0] issue_col,
    output logic             issue_ap_last
);
    typedef struct packed {
        logic             active;
        logic             ap;
        logic [BA_W-1:0]  ba;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] cnt;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [COL_W-1:0] blk_mask;
    logic             page_mode;
    logic             last_word;

    always_comb begin
        page_mode = cfg_burst[2];
        blk_mask  = page_mode ? {COL_W{1'b1}} : ((COL_W'(1) << cfg_burst[1:0]) - COL_W'(1));
        last_word = gen_q.active && !page_mode && (gen_q.cnt == blk_mask);
        gen_d     = gen_q;
        if (cmd_read) begin
            gen_d.active = 1'b1;
            gen_d.ap     = cmd_ap;
            gen_d.ba     = cmd_ba;
            gen_d.col    = cmd_col;
            gen_d.cnt    = '0;
        end else if (gen_q.active) begin
            gen_d.active = !last_word;
            gen_d.cnt    = gen_q.cnt + COL_W'(1);
            gen_d.col    = (gen_q.col & ~blk_mask) | ((gen_q.col + COL_W'(1)) & blk_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign issue_v       = gen_q.active;
    assign issue_ba      = gen_q.ba;
    assign issue_col     = gen_q.col;
    assign issue_ap_last = last_word && gen_q.ap;

    // R3
    block_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q.active && !cmd_read && !last_word && !page_mode)
        |=> ((gen_q.col & ~blk_mask) == ($past(gen_q.col) & ~blk_mask)));

    // R4
    page_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q.active && page_mode && !cmd_read)
        |=> (gen_q.active && gen_q.col == COL_W'($past(gen_q.col) + COL_W'(1))));
endmodule

// File: rtl/sdram_row_model.sv
module sdram_row_model #(
    parameter int COL_W  = 9,
    parameter int BA_W   = 2,
    parameter int DATA_W = 8
) (
    input  logic [BA_W-1:0]   rd_ba,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    import sdram_rd_pkg::*;
    logic [31:0] full_word;

    always_comb begin
        full_word = row_word(32'(rd_ba), 32'(rd_col));
        rd_data   = full_word[DATA_W-1:0];
    end
endmodule

// File: rtl/sdram_cl_pipe.sv
module sdram_cl_pipe #(
    parameter int DATA_W = 8,
    parameter int BA_W   = 2,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_cas_lat,
    input  logic              in_v,
    input  logic              in_ap_last,
    input  logic [BA_W-1:0]   in_ba,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_v,
    output logic              out_ap_last,
    output logic [BA_W-1:0]   out_ba,
    output logic [DATA_W-1:0] out_data
);
    localparam int NSTG = MAX_CL - 1;

    typedef struct packed {
        logic              v;
        logic              ap_last;
        logic [BA_W-1:0]   ba;
        logic [DATA_W-1:0] data;
    } stg_t;

    typedef struct packed {
        stg_t [NSTG:1] s;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    int    tap;
    stg_t  sel;

    always_comb begin
        pipe_d = pipe_q;
        pipe_d.s[1] = '{v: in_v, ap_last: in_ap_last, ba: in_ba, data: in_data};
        for (int i = 2; i <= NSTG; i++) pipe_d.s[i] = pipe_q.s[i-1];
        if (int'(cfg_cas_lat) >= MAX_CL)  tap = NSTG;
        else if (int'(cfg_cas_lat) < 2)   tap = 1;
        else                              tap = int'(cfg_cas_lat) - 1;
        sel = pipe_q.s[tap];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_v       = sel.v;
    assign out_ap_last = sel.ap_last && sel.v;
    assign out_ba      = sel.ba;
    assign out_data    = sel.data;
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq #(
    parameter int DATA_W = 8,
    parameter int COL_W  = 9,
    parameter int BANKS  = 4,
    parameter int MAX_CL = 3,
    localparam int BA_W  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_cas_lat,
    input  logic [2:0]        cfg_burst,
    input  logic              cmd_read,
    input  logic [BA_W-1:0]   cmd_ba,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    inout  wire  [DATA_W-1:0] dq,
    output logic              dq_oe,
    output logic [BANKS-1:0]  pre_done
);
    logic              iss_v, iss_ap_last, p_v, p_ap_last;
    logic [BA_W-1:0]   iss_ba, p_ba;
    logic [COL_W-1:0]  iss_col;
    logic [DATA_W-1:0] iss_data, p_data;

    typedef struct packed {
        logic [BANKS-1:0] pd;
    } top_t;
    top_t top_d, top_q;

    sdram_col_gen #(.COL_W(COL_W), .BA_W(BA_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .cmd_ba(cmd_ba),
        .cmd_col(cmd_col), .cmd_ap(cmd_ap), .cfg_burst(cfg_burst),
        .issue_v(iss_v), .issue_ba(iss_ba), .issue_col(iss_col),
        .issue_ap_last(iss_ap_last)
    );

    sdram_row_model #(.COL_W(COL_W), .BA_W(BA_W), .DATA_W(DATA_W)) u_rows (
        .rd_ba(iss_ba), .rd_col(iss_col), .rd_data(iss_data)
    );

    sdram_cl_pipe #(.DATA_W(DATA_W), .BA_W(BA_W), .MAX_CL(MAX_CL)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat),
        .in_v(iss_v), .in_ap_last(iss_ap_last), .in_ba(iss_ba), .in_data(iss_data),
        .out_v(p_v), .out_ap_last(p_ap_last), .out_ba(p_ba), .out_data(p_data)
    );

    always_comb begin
        top_d.pd = '0;
        if (p_ap_last) top_d.pd[p_ba] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign dq_oe    = p_v;
    assign dq       = p_v ? p_data : {DATA_W{1'bz}};
    assign pre_done = top_q.pd;

    // R1
    cl2_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && cfg_cas_lat == 2'd2) |-> ##2 dq_oe);

    // R1
    cl3_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && cfg_cas_lat == 2'd3) |-> ##3 dq_oe);

    // R8
    pd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pre_done));

    // R8
    pd_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_done != '0) |-> $past(dq_oe));
endmodule

// File: tb/sim_sdram_rd_seq.sv
module sim_sdram_rd_seq;
    localparam int DW = 8, CW = 5, NB = 4, HOR = 4096;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_cas_lat = 2'd2;
    logic [2:0] cfg_burst = 3'd2;
    logic cmd_read = 1'b0, cmd_ap = 1'b0;
    logic [1:0] cmd_ba = '0;
    logic [CW-1:0] cmd_col = '0;
    wire  [DW-1:0] dq;
    logic dq_oe;
    logic [NB-1:0] pre_done;

    sdram_rd_seq #(.DATA_W(DW), .COL_W(CW), .BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_burst(cfg_burst),
        .cmd_read(cmd_read), .cmd_ba(cmd_ba), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .dq(dq), .dq_oe(dq_oe), .pre_done(pre_done)
    );

    always #5 clk = ~clk;

    int cyc = 0, tests = 0, fails = 0;
    bit run_chk = 0, done = 0;
    string req = "R7";
    logic          e_oe [HOR];
    logic [DW-1:0] e_d  [HOR];
    logic [NB-1:0] e_pd [HOR];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] word_at(int b, int c);
        int v = 91 * b + 29 * c + 167;
        return v[DW-1:0];
    endfunction

    always @(negedge clk) begin
        if (run_chk && cyc < HOR) begin
            tests++;
            if (dq_oe !== e_oe[cyc] || (e_oe[cyc] && dq !== e_d[cyc]) || pre_done !== e_pd[cyc]) begin
                fails++;
                $display("FAIL %s cyc %0d: oe=%b dq=%h pd=%b expected oe=%b dq=%h pd=%b",
                         req, cyc, dq_oe, dq, pre_done, e_oe[cyc], e_d[cyc], e_pd[cyc]);
            end
        end
    end

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    // issue a READ in the current cycle; expected trace derived from R1..R10
    task automatic rd(int b, int c, bit ap);
        int cl    = int'(cfg_cas_lat);
        bit page  = (cfg_burst == 3'd7);
        int len   = page ? 300 : (1 << cfg_burst);
        int start = cyc + cl;
        for (int i = start; i < HOR; i++) begin
            e_oe[i] = 1'b0;
            e_d[i]  = '0;
            if (i > start) e_pd[i] = '0;
        end
        for (int j = 0; j < len; j++) begin
            int cc = page ? ((c + j) % (1 << CW)) : ((c & ~(len - 1)) | ((c + j) & (len - 1)));
            if (start + j < HOR) begin
                e_oe[start + j] = 1'b1;
                e_d[start + j]  = word_at(b, cc);
            end
        end
        if (ap && !page && start + len < HOR) e_pd[start + len] = NB'(1) << b;
        cmd_read = 1'b1; cmd_ba = 2'(b); cmd_col = CW'(c); cmd_ap = ap;
        @(negedge clk);
        cmd_read = 1'b0; cmd_ap = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < HOR; i++) begin e_oe[i] = 0; e_d[i] = 0; e_pd[i] = 0; end
        idle(3);
        // R7: reset state
        tests++;
        if (dq_oe !== 1'b0 || pre_done !== '0) begin
            fails++;
            $display("FAIL R7 reset: oe=%b pd=%b expected oe=0 pd=0", dq_oe, pre_done);
        end
        rst_n = 1'b1;
        idle(2);
        run_chk = 1;

        // R1 R3 R10: CL3, length 4, unaligned start
        req = "R1"; cfg_cas_lat = 2'd3; cfg_burst = 3'd2;
        rd(1, 6, 0); idle(10);
        // R2 R3: CL2, length 8, start 13
        req = "R3"; cfg_cas_lat = 2'd2; cfg_burst = 3'd3;
        rd(2, 13, 0); idle(12);
        // R2: lengths 1 and 2 at both latencies
        req = "R2"; cfg_burst = 3'd0; rd(3, 9, 0); idle(6);
        cfg_burst = 3'd1; rd(0, 31, 0); idle(6);
        cfg_cas_lat = 2'd3; cfg_burst = 3'd0; rd(1, 4, 0); idle(6);
        cfg_burst = 3'd1; rd(2, 5, 0); idle(6);
        // R6: back-to-back length 4 READs, 4 cycles apart
        req = "R6"; cfg_cas_lat = 2'd2; cfg_burst = 3'd2;
        rd(0, 1, 0); idle(3); rd(3, 10, 0); idle(3); rd(1, 22, 0); idle(10);
        // R5 R9: truncation of an auto-precharge length-8 burst
        req = "R5"; cfg_cas_lat = 2'd3; cfg_burst = 3'd3;
        rd(2, 3, 1); idle(2); rd(1, 17, 0); idle(14);
        // R8: completed auto-precharge bursts, both latencies
        req = "R8"; cfg_burst = 3'd2; rd(2, 7, 1); idle(10);
        cfg_cas_lat = 2'd2; cfg_burst = 3'd0; rd(3, 0, 1); idle(6);
        // R8 R6: back-to-back, first with auto precharge
        cfg_burst = 3'd1; rd(1, 2, 1); idle(1); rd(0, 8, 1); idle(8);
        // R4: full page from column 29 wraps past 31, then truncated
        req = "R4"; cfg_burst = 3'd7;
        rd(1, 29, 0); idle(40);
        cfg_burst = 3'd1; rd(2, 12, 0); idle(8);
        // R9: full page with auto precharge, truncated, no pulse
        req = "R9"; cfg_cas_lat = 2'd3; cfg_burst = 3'd7;
        rd(3, 30, 1); idle(5);
        cfg_burst = 3'd2; rd(0, 0, 0); idle(10);
        // R7: bus idle again
        req = "R7"; idle(5);
        run_chk = 0;
        finish_run();
    end
endmodule